// File: doc/BRIEF.md
# Restartable Byte Translation Engine

This block rewrites a byte string in memory through a lookup table. For every string byte it reads the byte, uses it as an unsigned offset from the table base, reads the table entry found there and stores that entry back in the string byte's place. The memory behind it is paged, and any access may come back with a fault.

The engine runs every operation in two passes so that a fault never leaves it half done. The first pass is a rehearsal. It walks the whole string on hidden cursor registers and issues every read the real pass will issue, but it issues no writes. If any read faults, the engine reports the faulting address and returns to idle. Nothing in memory and nothing in its visible registers has changed at that point, so software services the page and simply issues the same start again. Each start begins a new rehearsal from the first byte. Only when a rehearsal finishes clean does the engine run the operation a second time. In that pass the visible pointer and count advance and the writes are performed.

Top module: `translate_engine`

## Requirements
- R1: After reset, busy, done, fault, mem_req and mem_we are all 0, and vis_ptr and vis_cnt are 0.
- R2: On completion, the string byte at each address str_base+i (i from 0 to len-1, in ascending order, with all address arithmetic modulo 2^AW) holds the table byte at tbl_base+b. Here b is the string byte's value at the moment that step reads it, zero-extended.
- R3: During the rehearsal pass, mem_we stays 0. No write is issued until every rehearsal read has been acknowledged without a fault.
- R4: A fault response (mem_ack=1 with mem_fault=1) during the rehearsal does three things. It raises fault for exactly one cycle, it sets fault_addr to the address that was requested, and it returns the engine to idle (busy=0). Memory is left unchanged.
- R5: A start issued after a fault begins again from the first string byte. The first read of the new operation is at str_base.
- R6: A start with len=0 raises done on the next clock edge. It issues no memory request and leaves vis_ptr and vis_cnt unchanged.
- R7: vis_ptr and vis_cnt change only during the commit pass. A faulted operation leaves them at their earlier values. After a completed operation, vis_ptr=str_base+len and vis_cnt=0.
- R8: done is high for exactly one cycle, after the final write is acknowledged, and busy is 0 from that cycle on. A start while busy=1 is ignored.
- R9: A fault-free operation of length n issues exactly 4n acknowledged reads and n writes.
- R10: String and table operands may cross page boundaries and wrap past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| str_base | input | AW | Address of the first string byte |
| tbl_base | input | AW | Address of table entry 0 |
| len | input | LW | Number of string bytes |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_fault | input | 1 | With mem_ack: page not present, access not performed |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_addr | output | AW | Address of the last faulting access |
| vis_ptr | output | AW | Visible string cursor |
| vis_cnt | output | LW | Visible remaining count |

## Verification
The bench checks fully present memory under random bases and lengths, including lengths of 0, 1 and 255. These tell correct per-byte mapping apart from errors in ordering, offsets and counting. Tables and strings placed across page and address-space boundaries separate correct modulo arithmetic from carry mistakes. Runs with one page missing show whether the first fault is reported at the right address with memory and cursors untouched. The retry that follows shows the restart from byte zero and the commit. A start pulsed during a run tells whether the engine ignores it.

// File: rtl/tte_pkg.sv
package tte_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STR,
    ST_TBL,
    ST_WR
  } tte_state_t;
endpackage

// File: rtl/tte_operands.sv
// Holds the operand values captured when an operation is accepted.
module tte_operands #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [AW-1:0] str_in,
  input  logic [AW-1:0] tbl_in,
  input  logic [LW-1:0] len_in,
  output logic [AW-1:0] str_q,
  output logic [AW-1:0] tbl_q,
  output logic [LW-1:0] len_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      str_q <= '0;
      tbl_q <= '0;
      len_q <= '0;
    end else if (capture) begin
      str_q <= str_in;
      tbl_q <= tbl_in;
      len_q <= len_in;
    end
  end
endmodule

// File: rtl/tte_cursor.sv
// Pointer and down-counter pair: used for both the hidden and the visible cursor.
module tte_cursor #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] load_ptr,
  input  logic [LW-1:0] load_cnt,
  output logic [AW-1:0] ptr,
  output logic [LW-1:0] cnt,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      cnt <= '0;
    end else if (load) begin
      ptr <= load_ptr;
      cnt <= load_cnt;
    end else if (step) begin
      ptr <= ptr + AW'(1);
      cnt <= cnt - LW'(1);
    end
  end

  assign last = (cnt == LW'(1));
endmodule

// File: rtl/tte_ctrl.sv
// Sequencer: rehearsal pass on the hidden cursor, then commit pass on the visible one.
module tte_ctrl
  import tte_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] len_in,
  input  logic          mem_ack,
  input  logic          mem_fault,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] mem_addr,
  input  logic          sh_last,
  input  logic          vis_last,
  output tte_state_t    state,
  output logic          pass_dry,
  output logic          capture,
  output logic          sh_step,
  output logic          vis_load,
  output logic          vis_step,
  output logic [DW-1:0] byte_q,
  output logic [DW-1:0] entry_q,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] fault_addr
);
  logic ok_ack;
  logic bad_ack;

  assign ok_ack   = mem_ack && !mem_fault;
  assign bad_ack  = mem_ack && mem_fault;
  assign capture  = (state == ST_IDLE) && start && (len_in != '0);
  assign sh_step  = (state == ST_TBL) && ok_ack && pass_dry && !sh_last;
  assign vis_load = (state == ST_TBL) && ok_ack && pass_dry && sh_last;
  assign vis_step = (state == ST_WR) && ok_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pass_dry   <= 1'b1;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_addr <= '0;
      byte_q     <= '0;
      entry_q    <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (state != ST_IDLE && bad_ack) begin
        fault      <= 1'b1;
        fault_addr <= mem_addr;
        pass_dry   <= 1'b1;
        state      <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (start) begin
              if (len_in == '0) begin
                done <= 1'b1;
              end else begin
                pass_dry <= 1'b1;
                state    <= ST_STR;
              end
            end
          end
          ST_STR: begin
            if (ok_ack) begin
              byte_q <= mem_rdata;
              state  <= ST_TBL;
            end
          end
          ST_TBL: begin
            if (ok_ack) begin
              entry_q <= mem_rdata;
              if (pass_dry) begin
                if (sh_last) pass_dry <= 1'b0;
                state <= ST_STR;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (ok_ack) begin
              if (vis_last) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                state <= ST_STR;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/translate_engine.sv
module translate_engine
  import tte_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] str_base,
  input  logic [AW-1:0] tbl_base,
  input  logic [LW-1:0] len,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_fault,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] fault_addr,
  output logic [AW-1:0] vis_ptr,
  output logic [LW-1:0] vis_cnt
);
  localparam int NCUR = 2;   // index 0: hidden rehearsal cursor, 1: visible cursor

  tte_state_t    state;
  logic          pass_dry;
  logic          capture, sh_step, vis_load, vis_step;
  logic [DW-1:0] byte_q, entry_q;
  logic [AW-1:0] str_q, tbl_q;
  logic [LW-1:0] len_q;

  logic [NCUR-1:0]         cur_load, cur_step, cur_last;
  logic [NCUR-1:0][AW-1:0] cur_ptr;
  logic [NCUR-1:0][LW-1:0] cur_cnt;
  logic [NCUR-1:0][AW-1:0] cur_lptr;
  logic [NCUR-1:0][LW-1:0] cur_lcnt;

  tte_operands #(.AW(AW), .LW(LW)) u_ops (
    .clk(clk), .rst(rst), .capture(capture),
    .str_in(str_base), .tbl_in(tbl_base), .len_in(len),
    .str_q(str_q), .tbl_q(tbl_q), .len_q(len_q)
  );

  assign cur_load = {vis_load, capture};
  assign cur_step = {vis_step, sh_step};
  assign cur_lptr = {str_q, str_base};
  assign cur_lcnt = {len_q, len};

  for (genvar g = 0; g < NCUR; g++) begin : g_cur
    tte_cursor #(.AW(AW), .LW(LW)) u_cur (
      .clk(clk), .rst(rst),
      .load(cur_load[g]), .step(cur_step[g]),
      .load_ptr(cur_lptr[g]), .load_cnt(cur_lcnt[g]),
      .ptr(cur_ptr[g]), .cnt(cur_cnt[g]), .last(cur_last[g])
    );
  end

  tte_ctrl #(.AW(AW), .LW(LW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .len_in(len),
    .mem_ack(mem_ack), .mem_fault(mem_fault), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr),
    .sh_last(cur_last[0]), .vis_last(cur_last[1]),
    .state(state), .pass_dry(pass_dry), .capture(capture),
    .sh_step(sh_step), .vis_load(vis_load), .vis_step(vis_step),
    .byte_q(byte_q), .entry_q(entry_q),
    .done(done), .fault(fault), .fault_addr(fault_addr)
  );

  // Request signals decode only registered state.
  always_comb begin
    mem_addr = '0;
    unique case (state)
      ST_STR:  mem_addr = pass_dry ? cur_ptr[0] : cur_ptr[1];
      ST_TBL:  mem_addr = tbl_q + AW'(byte_q);
      ST_WR:   mem_addr = cur_ptr[1];
      default: mem_addr = '0;
    endcase
  end

  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WR);
  assign mem_wdata = entry_q;
  assign busy      = (state != ST_IDLE);
  assign vis_ptr   = cur_ptr[1];
  assign vis_cnt   = cur_cnt[1];
endmodule

// File: rtl/tte_checker.sv
module tte_checker #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [LW-1:0] len,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [LW-1:0] vis_cnt,
  input logic          pass_dry
);
  p_no_write_in_rehearsal_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !pass_dry);

  p_fault_returns_idle_r4: assert property (@(posedge clk) disable iff (rst)
    fault |-> !busy);

  p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_zero_len_done_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && len == '0) |=> (done && !busy));

  p_vis_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    pass_dry |=> (!pass_dry || $stable(vis_cnt)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind translate_engine tte_checker #(.AW(AW), .LW(LW)) u_tte_checker (
  .clk(clk), .rst(rst), .start(start), .len(len), .busy(busy),
  .done(done), .fault(fault), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .vis_cnt(vis_cnt),
  .pass_dry(pass_dry)
);

// File: tb/test_translate_engine.sv
module test_translate_engine;
  localparam int AW  = 10;
  localparam int LW  = 8;
  localparam int DW  = 8;
  localparam int MSZ = 1 << AW;
  localparam int PB  = 6;              // 64-byte pages
  localparam int NP  = MSZ >> PB;

  logic clk = 0, rst = 1, start = 0;
  logic [AW-1:0] str_base = 0, tbl_base = 0;
  logic [LW-1:0] len = 0;
  logic mem_req, mem_we, mem_ack, mem_fault, busy, done, fault;
  logic [AW-1:0] mem_addr, fault_addr, vis_ptr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [LW-1:0] vis_cnt;

  logic [7:0] mem [MSZ];
  logic [7:0] expm [MSZ];
  logic [NP-1:0] present;
  int nrd, nwr, first_rd;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  translate_engine #(.AW(AW), .LW(LW), .DW(DW)) i_translate_engine (.*);

  // Paged memory model: one-cycle response, fault if page absent.
  initial begin mem_ack = 0; mem_fault = 0; mem_rdata = 0; end
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 0; mem_fault <= 0;
    end else begin
      mem_ack <= 0; mem_fault <= 0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1;
        if (!present[mem_addr[AW-1:PB]]) mem_fault <= 1;
        else if (mem_we) begin
          mem[mem_addr] <= mem_wdata; nwr = nwr + 1;
        end else begin
          mem_rdata <= mem[mem_addr];
          if (nrd == 0) first_rd = int'(mem_addr);
          nrd = nrd + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wrap(input int a);
    return a & (MSZ - 1);
  endfunction

  // First address the rehearsal would fault on, or -1.
  function automatic int first_fault(input int s, input int t, input int l);
    for (int i = 0; i < l; i++) begin
      int a = wrap(s + i);
      int b;
      if (!present[a >> PB]) return a;
      b = wrap(t + int'(mem[a]));
      if (!present[b >> PB]) return b;
    end
    return -1;
  endfunction

  task automatic golden(input int s, input int t, input int l);
    for (int i = 0; i < MSZ; i++) expm[i] = mem[i];
    for (int i = 0; i < l; i++) begin
      int a = wrap(s + i);
      expm[a] = expm[wrap(t + int'(expm[a]))];
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, where = 0;
    for (int i = 0; i < MSZ; i++)
      if (mem[i] !== expm[i]) begin bad++; where = i; end
    chk(bad == 0, req, "memory mismatches (last addr in actual)", where, 0);
  endtask

  int cyc;
  task automatic run_op(input int s, input int t, input int l, input int poke);
    nrd = 0; nwr = 0; first_rd = -1; cyc = 0;
    str_base = AW'(s); tbl_base = AW'(t); len = LW'(l);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && !fault && cyc < 20000) begin
      start = (cyc == poke);
      if (cyc == poke) begin str_base = AW'(s + 7); len = 8'd3; end
      @(negedge clk);
      cyc++;
    end
    start = 0;
    if (cyc >= 20000) chk(0, "R8", "operation timeout", cyc, 0);
  endtask

  // Full successful operation with all checks.
  task automatic good_op(input int s, input int t, input int l, input int poke);
    golden(s, t, l);
    run_op(s, t, l, poke);
    chk(done === 1, "R2", "done at end", done, 1);
    cmp_mem("R2");
    chk(nrd == 4 * l, "R9", "read count", nrd, 4 * l);
    chk(nwr == l, "R9", "write count", nwr, l);
    chk(vis_ptr == AW'(s + l) && vis_cnt == 0, "R7", "visible pointer after commit",
        int'(vis_ptr), wrap(s + l));
    @(negedge clk);
    chk(!done && !busy, "R8", "done single cycle then idle", done, 0);
  endtask

  // Operation expected to fault, then serviced and retried.
  task automatic fault_op(input int s, input int t, input int l, input int page);
    int ff;
    int vp0, vc0;
    present = '1;
    present[page] = 1'b0;
    ff = first_fault(s, t, l);
    if (ff < 0) begin
      present = '1;
      good_op(s, t, l, -1);
      return;
    end
    vp0 = int'(vis_ptr); vc0 = int'(vis_cnt);
    for (int i = 0; i < MSZ; i++) expm[i] = mem[i];
    run_op(s, t, l, -1);
    chk(fault === 1, "R4", "fault raised", fault, 1);
    chk(int'(fault_addr) == ff, "R4", "fault address", int'(fault_addr), ff);
    chk(!busy, "R4", "idle after fault", busy, 0);
    chk(nwr == 0, "R3", "no writes before fault", nwr, 0);
    cmp_mem("R3");
    chk(int'(vis_ptr) == vp0 && int'(vis_cnt) == vc0, "R7", "visible cursor unchanged",
        int'(vis_cnt), vc0);
    @(negedge clk);
    chk(!fault, "R4", "fault single cycle", fault, 0);
    present = '1;
    golden(s, t, l);
    run_op(s, t, l, -1);
    chk(first_rd == s, "R5", "retry first read address", first_rd, s);
    cmp_mem("R5");
    chk(nrd == 4 * l && nwr == l, "R9", "retry access count", nwr, l);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "R8", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < MSZ; i++) mem[i] = 8'($urandom);
    present = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fault && !mem_req && !mem_we, "R1", "reset outputs", busy, 0);
    chk(vis_ptr == 0 && vis_cnt == 0, "R1", "reset visible cursor", int'(vis_cnt), 0);

    // R6 zero length
    run_op(100, 200, 0, -1);
    chk(done === 1 && cyc == 0, "R6", "zero length done next cycle", cyc, 0);
    chk(nrd + nwr == 0, "R6", "zero length no accesses", nrd + nwr, 0);
    chk(vis_ptr == 0 && vis_cnt == 0, "R6", "zero length visible unchanged", int'(vis_ptr), 0);
    @(negedge clk);

    // Directed: single byte, full length, crossing pages and wrapping (R10)
    good_op(10, 300, 1, -1);
    good_op(500, 700, 255, -1);
    good_op(MSZ - 30, MSZ - 100, 90, -1);   // R10 string and table wrap
    // R8 start while busy ignored
    good_op(64, 512, 20, 5);

    // R4/R5 directed fault: table page missing
    fault_op(128, 900, 40, 900 >> PB);
    // string runs into missing page after some bytes
    fault_op(60, 400, 30, 1);

    // Random mix
    for (int k = 0; k < 24; k++) begin
      int s = int'($urandom % MSZ);
      int t = int'($urandom % MSZ);
      int l = int'($urandom % 256);
      if (k % 3 == 2) fault_op(s, t, l, int'($urandom % NP));
      else good_op(s, t, l, (k % 4 == 1) ? 3 : -1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule